// File: doc/BRIEF.md
# Counter and Compare Timer

This peripheral keeps a free-running counter that advances by one on every rising clock edge and is visible to software through a small register bus (address, write data, write strobe, combinational read data). Two compare registers sit next to it: a full-width one and a narrower one that watches only the low bits of the counter. When either register equals the part of the counter it watches, a sticky interrupt flag is raised. The flag stays high until software writes that compare register again.

Besides the two compare flags, the block exports two fixed counter bits and their complements as interrupt sources. These give square waves of fixed period that a system can use as periodic ticks. All six request lines come out on one vector, which is meant to feed the cause inputs of an interrupt controller directly.

Top module: `tmr_top`

## Requirements
- R1: After reset the counter reads zero. Afterwards it increments by one on every rising clock edge and wraps from all ones to zero. It is read at address 0xF000_0050.
- R2: A write to the counter address has no effect. The counter value read in the next cycle is exactly one more than in the cycle of the write.
- R3: The first compare register is CMP_W bits wide (32 by default), is read and written at 0xF000_0060, and resets to zero.
- R4: At every clock edge where the first compare register equals the counter and no write to it is in progress, the first compare flag is set. The flag appears on irq_o bit 4 one cycle later. Because the register resets to zero, this flag is raised at the first edge after reset.
- R5: The second compare register is at 0xF000_0070 and keeps only its low CMP2_W bits (24 by default). Write data above that width is discarded, and those bits read as zero.
- R6: The second compare flag is set when the second compare register equals the low CMP2_W bits of the counter. It appears on irq_o bit 5 one cycle later, and it repeats at every wrap of those low bits.
- R7: Each compare flag stays set until its own compare register is written. Such a write clears the flag even when a match occurs at the same edge; in that case the write wins.
- R8: irq_o bit 0 is the complement of counter bit TAP_HI and bit 1 is counter bit TAP_HI. Bit 2 is the complement of counter bit TAP_LO and bit 3 is counter bit TAP_LO. TAP_HI defaults to 18 and TAP_LO to 16.
- R9: A read from any address other than the three mapped ones returns zero, and a write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 32 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 6 | Interrupt requests: ~tap_hi, tap_hi, ~tap_lo, tap_lo, compare, compare2 |

## Verification
The case that needs care is a software write to a compare register that falls on the same edge where the old value of that register matches the counter. In that edge the flag is asked both to set and to clear. The bench provokes this case by loading a compare value a few counts ahead of the counter, waiting until the counter reads exactly that value, and then issuing a write to the same register in that cycle. The flag must be low afterwards. A cycle-by-cycle model of the counter and both flags compares the whole interrupt vector on every cycle of the run, so a flag that sets late, sets early or drops by itself is also caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int IRQ_N  = 6;

    typedef enum int {
        IRQ_HI_N = 0,
        IRQ_HI   = 1,
        IRQ_LO_N = 2,
        IRQ_LO   = 3,
        IRQ_CMP  = 4,
        IRQ_CMP2 = 5
    } irq_idx_e;

    localparam logic [DATA_W-1:0] ADDR_COUNT = 32'hF000_0050;
    localparam logic [DATA_W-1:0] ADDR_CMP   = 32'hF000_0060;
    localparam logic [DATA_W-1:0] ADDR_CMP2  = 32'hF000_0070;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_o == W'($past(cnt_o) + 1'b1)));

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int CMP_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMP_W-1:0]  wr_val,
    input  logic [CMP_W-1:0]  cnt_lo,
    output logic [DATA_W-1:0] val_o,
    output logic              flag_o
);

    typedef struct packed {
        logic [CMP_W-1:0] val;
        logic             flag;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit  = (st_q.val == cnt_lo);
        st_d = st_q;
        if (hit) st_d.flag = 1'b1;
        if (wr_en) begin
            st_d.val  = wr_val;
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o  = DATA_W'(st_q.val);
    assign flag_o = st_q.flag;

    // R7
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !flag_o);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !wr_en) |=> flag_o);

    // R4
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (val_o[CMP_W-1:0] == cnt_lo)) |=> flag_o);

    // R3
    wr_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (val_o == DATA_W'($past(wr_val))));

endmodule

// File: rtl/tmr_irq_map.sv
module tmr_irq_map
    import tmr_pkg::*;
(
    input  logic             tap_hi,
    input  logic             tap_lo,
    input  logic             cmp_flag,
    input  logic             cmp2_flag,
    output logic [IRQ_N-1:0] irq_o
);

    always_comb begin
        irq_o           = '0;
        irq_o[IRQ_HI_N] = ~tap_hi;
        irq_o[IRQ_HI]   =  tap_hi;
        irq_o[IRQ_LO_N] = ~tap_lo;
        irq_o[IRQ_LO]   =  tap_lo;
        irq_o[IRQ_CMP]  =  cmp_flag;
        irq_o[IRQ_CMP2] =  cmp2_flag;
    end

endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int CMP_W  = 32,
    parameter int CMP2_W = 24,
    parameter int TAP_HI = 18,
    parameter int TAP_LO = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [IRQ_N-1:0]  irq_o
);

    localparam int N_CMP = 2;

    logic [DATA_W-1:0] cnt;
    logic [N_CMP-1:0]  cmp_wr;
    logic [N_CMP-1:0]  cmp_flag;
    logic [DATA_W-1:0] cmp_val [N_CMP];

    tmr_counter #(.W(DATA_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        localparam int CW = (g == 0) ? CMP_W : CMP2_W;
        localparam logic [DATA_W-1:0] MY_ADDR = (g == 0) ? ADDR_CMP : ADDR_CMP2;

        assign cmp_wr[g] = bus_we && (bus_addr == MY_ADDR);

        tmr_compare #(.CMP_W(CW), .DATA_W(DATA_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cmp_wr[g]),
            .wr_val (bus_wdata[CW-1:0]),
            .cnt_lo (cnt[CW-1:0]),
            .val_o  (cmp_val[g]),
            .flag_o (cmp_flag[g])
        );
    end

    tmr_irq_map u_irq (
        .tap_hi    (cnt[TAP_HI]),
        .tap_lo    (cnt[TAP_LO]),
        .cmp_flag  (cmp_flag[0]),
        .cmp2_flag (cmp_flag[1]),
        .irq_o     (irq_o)
    );

    always_comb begin
        case (bus_addr)
            ADDR_COUNT: bus_rdata = cnt;
            ADDR_CMP:   bus_rdata = cmp_val[0];
            ADDR_CMP2:  bus_rdata = cmp_val[1];
            default:    bus_rdata = '0;
        endcase
    end

    // R2
    cnt_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == ADDR_COUNT)) |=> (cnt == DATA_W'($past(cnt) + 1'b1)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr != ADDR_COUNT) && (bus_addr != ADDR_CMP) && (bus_addr != ADDR_CMP2))
        |-> (bus_rdata == '0));

    if (CMP2_W < DATA_W) begin : g_cmp2_hi
        // R5
        cmp2_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_CMP2) |-> (bus_rdata[DATA_W-1:CMP2_W] == '0));
    end

endmodule

// File: tb/test_tmr_top.sv
`timescale 1ns/1ps
module test_tmr_top;

    localparam int HI = 6;
    localparam int LO = 4;
    localparam int W2 = 8;
    localparam logic [31:0] A_CNT  = 32'hF000_0050;
    localparam logic [31:0] A_CMP  = 32'hF000_0060;
    localparam logic [31:0] A_CMP2 = 32'hF000_0070;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = A_CNT;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_top #(.CMP_W(32), .CMP2_W(W2), .TAP_HI(HI), .TAP_LO(LO)) i_tmr_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Reference model built from the requirements
    logic [31:0]   exp_cnt;
    logic [31:0]   m_c1;
    logic [W2-1:0] m_c2;
    logic          m_f1, m_f2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_cnt <= '0; m_c1 <= '0; m_c2 <= '0; m_f1 <= 1'b0; m_f2 <= 1'b0;
        end else begin
            exp_cnt <= exp_cnt + 1;
            if (bus_we && bus_addr == A_CMP) begin
                m_c1 <= bus_wdata; m_f1 <= 1'b0;
            end else if (m_c1 == exp_cnt) m_f1 <= 1'b1;
            if (bus_we && bus_addr == A_CMP2) begin
                m_c2 <= bus_wdata[W2-1:0]; m_f2 <= 1'b0;
            end else if (m_c2 == exp_cnt[W2-1:0]) m_f2 <= 1'b1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Every-cycle comparison of the interrupt vector
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 taps", {28'd0, irq_o[3:0]},
                  {28'd0, exp_cnt[LO], ~exp_cnt[LO], exp_cnt[HI], ~exp_cnt[HI]});
            check("R4 R7 compare flag", {31'd0, irq_o[4]}, {31'd0, m_f1});
            check("R6 R7 compare2 flag", {31'd0, irq_o[5]}, {31'd0, m_f2});
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A_CNT;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] target;
        logic [W2-1:0] t2;

        // Reset state
        #12;
        rd(A_CNT, d);  check("R1 reset counter", d, 32'd0);
        check("R8 reset irq", {26'd0, irq_o}, 32'h0000_0005);
        rd(A_CMP, d);  check("R3 reset compare", d, 32'd0);
        rd(A_CMP2, d); check("R5 reset compare2", d, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R6: both registers reset to zero and match at the first edge
        @(negedge clk);
        check("R4 flag after reset", {31'd0, irq_o[4]}, 32'd1);
        check("R6 flag after reset", {31'd0, irq_o[5]}, 32'd1);

        // R1: counting
        repeat (40) begin
            @(negedge clk);
            rd(A_CNT, d); check("R1 counter", d, exp_cnt);
        end

        // R2: counter write ignored
        @(negedge clk);
        rd(A_CNT, d);
        target = d;
        bus_addr = A_CNT; bus_wdata = 32'hDEAD_BEEF; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_CNT, d); check("R2 counter write ignored", d, target + 1);

        // R3 R4: load a compare value ahead and watch it fire
        @(negedge clk);
        target = exp_cnt + 20;
        wr(A_CMP, target);
        rd(A_CMP, d); check("R3 compare readback", d, target);
        check("R7 cleared by write", {31'd0, irq_o[4]}, 32'd0);
        while (exp_cnt != target) @(negedge clk);
        check("R4 no flag before match", {31'd0, irq_o[4]}, 32'd0);
        @(negedge clk);
        check("R4 flag one cycle after match", {31'd0, irq_o[4]}, 32'd1);
        repeat (30) @(negedge clk);
        check("R7 flag sticky", {31'd0, irq_o[4]}, 32'd1);

        // R5: narrow register drops upper bits
        wr(A_CMP2, 32'hABCD_EF12);
        rd(A_CMP2, d); check("R5 compare2 upper bits zero", d, 32'h0000_0012);

        // R6: narrow match against low counter bits
        @(negedge clk);
        t2 = W2'(exp_cnt + 10);
        wr(A_CMP2, {24'hFFFFFF, t2});
        while (exp_cnt[W2-1:0] != t2) @(negedge clk);
        check("R6 no flag before match", {31'd0, irq_o[5]}, 32'd0);
        @(negedge clk);
        check("R6 flag after low-bit match", {31'd0, irq_o[5]}, 32'd1);

        // R7: write and match at the same edge, write wins
        @(negedge clk);
        target = exp_cnt + 8;
        wr(A_CMP, target);
        while (exp_cnt != target) @(negedge clk);
        bus_addr = A_CMP; bus_wdata = 32'h0000_0005; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A_CNT;
        check("R7 write beats match", {31'd0, irq_o[4]}, 32'd0);
        rd(A_CMP, d); check("R7 new compare value", d, 32'h0000_0005);

        // R7 on the narrow register
        @(negedge clk);
        t2 = W2'(exp_cnt + 8);
        wr(A_CMP2, {24'd0, t2});
        while (exp_cnt[W2-1:0] != t2) @(negedge clk);
        bus_addr = A_CMP2; bus_wdata = 32'h0000_0001; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A_CNT;
        check("R7 compare2 write beats match", {31'd0, irq_o[5]}, 32'd0);

        // R9: unmapped read and write
        rd(32'hF000_0080, d); check("R9 unmapped read", d, 32'd0);
        rd(32'h0000_0060, d); check("R9 partial address read", d, 32'd0);
        wr(32'hF000_0061, 32'h1234_5678);
        rd(A_CMP, d); check("R9 unmapped write leaves compare", d, 32'h0000_0005);

        // Long sweep: several wraps of taps and the narrow comparator
        bus_addr = A_CNT;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            rd(A_CNT, d); check("R1 counter sweep", d, exp_cnt);
            if (i % 300 == 0) begin
                wr(A_CMP2, i);
                wr(A_CMP, exp_cnt + 50);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule